// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block produces the reset for a processor from three independent causes: a supply-good flag delivered by an external voltage comparator, an active-low manual reset request, and a watchdog that expects the processor to toggle a pin regularly. Every cause feeds one shared stretch timer, so whichever cause fires, the reset stays asserted until all causes have been quiet for one full reset interval. Reset is driven on two pins of opposite polarity.

The watchdog input comes with a separate drive-valid flag; while that flag is low the pin is treated as floating and the watchdog does nothing. The manual request is synchronized and then debounced, so only a level that stays put for a programmed number of cycles is accepted. All intervals are parameters in clock cycles. The supply flag, watchdog pin, drive-valid flag and manual request are each passed through a two-flop synchronizer, which adds two cycles of latency to every cause.

Top module: `supv_reset_ctrl`

## Requirements
- R1: When `supply_ok_i` goes low, `cpu_rst_o` is 1 at the third rising clock edge after the change, whatever the stretch counter holds; a low pulse of a single cycle is enough.
- R2: After `supply_ok_i` returns high (with no other cause active), `cpu_rst_o` returns to 0 at rising edge RST_CYCLES+2 counted from the edge that first sees the high level.
- R3: Any rising or falling edge on `wdog_i` while `wdog_drv_i` is 1 restarts the watchdog count; toggling `wdog_i` every P cycles never causes a reset when P is at most WDOG_CYCLES and does cause one when P exceeds it.
- R4: With `wdog_drv_i` at 1 and no edge on `wdog_i`, a watchdog reset asserts exactly WDOG_CYCLES cycles after a reset release and holds `cpu_rst_o` at 1 for exactly RST_CYCLES cycles.
- R5: The watchdog count is held at zero while reset is asserted and starts from zero at each release, so an idle watchdog yields a steady pattern of WDOG_CYCLES cycles released and RST_CYCLES cycles asserted.
- R6: While `wdog_drv_i` is 0 the watchdog never causes a reset; when `wdog_drv_i` goes to 1 the count starts from zero, and with no edge reset asserts at the rising edge WDOG_CYCLES+2 counted from the edge that first sees the flag high.
- R7: A manual request (`man_rst_n_i` at 0) held for w >= DEB_CYCLES cycles asserts reset at edge DEB_CYCLES+3 after the falling level is applied and keeps it asserted for w+RST_CYCLES-1 cycles in total.
- R8: A manual request shorter than DEB_CYCLES cycles has no effect on either reset output.
- R9: `cpu_rst_o` is active high, `cpu_rst_n_o` is active low, and the two are always complementary.
- R10: A cause that reappears while reset is being stretched reloads the interval: release then comes RST_CYCLES+2 edges after the last cause clears.
- R11: While `rst_n` is 0 reset is asserted on both outputs; after `rst_n` rises with the supply good, reset releases at edge RST_CYCLES+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset, released synchronously |
| supply_ok_i | input | 1 | Supply-good flag from the external comparator, 1 = supply above threshold |
| wdog_i | input | 1 | Watchdog kick pin, any edge restarts the watchdog |
| wdog_drv_i | input | 1 | 1 = watchdog pin is driven, 0 = floating or tri-stated (watchdog disabled) |
| man_rst_n_i | input | 1 | Manual reset request, active low |
| cpu_rst_n_o | output | 1 | Processor reset, active low |
| cpu_rst_o | output | 1 | Processor reset, active high |

## Verification
The embedded assertions check on every cycle that a synchronized supply-low level forces reset on the next edge, that reset releases only after a full interval of quiet causes, that the watchdog count sits at zero while disabled, on an edge and during reset, and that the debouncer accepts a level only after its full hold count. What only the bench scenarios can show are the end-to-end latencies at the pins: the exact edge of assertion and release for each cause, the boundary where a manual pulse becomes long enough to count, the watchdog kick period that just avoids a timeout, and the reload of the interval by a cause arriving mid-stretch.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // One flag per reset cause, all active high.
  typedef struct packed {
    logic supply_low;
    logic manual;
    logic wdog;
  } supv_cause_t;

  // Bit order of the synchronizer bundle in the top.
  localparam int unsigned SYNC_SUPPLY = 3;
  localparam int unsigned SYNC_MANUAL = 2;
  localparam int unsigned SYNC_WDLVL  = 1;
  localparam int unsigned SYNC_WDDRV  = 0;
  localparam int unsigned SYNC_WIDTH  = 4;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned          WIDTH   = 1,
  parameter int unsigned          STAGES  = 2,
  parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = async_i;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= RST_VAL;
        end else begin
          stage_q[g] <= stage_d[g];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/supv_debounce.sv
module supv_debounce #(
  parameter int unsigned DEB_CYCLES = 4,
  parameter logic        RST_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o
);

  localparam int unsigned CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic          level_q, level_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          differ, at_last, level_en;

  always_comb begin
    differ   = (raw_i != level_q);
    at_last  = (cnt_q == LAST);
    level_en = differ && at_last;
    level_d  = level_en ? raw_i : level_q;
    if (differ && !at_last) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= RST_LEVEL;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (level_en) begin
        level_q <= level_d;
      end
    end
  end

  assign level_o = level_q;

  // A new level is taken only after the full hold count.
  assert_accept_after_hold_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(cnt_q) == LAST)
  );

  // The counter never runs past its limit.
  assert_deb_no_overflow_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST
  );

endmodule

// File: rtl/supv_wdog.sv
module supv_wdog #(
  parameter int unsigned WDOG_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_lvl_i,
  input  logic wd_drv_i,
  input  logic hold_i,
  output logic expire_o
);

  localparam int unsigned CW = $clog2(WDOG_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WDOG_CYCLES - 1);

  logic          prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          kick, clear, at_last;

  always_comb begin
    kick     = wd_drv_i && (wd_lvl_i != prev_q);
    clear    = hold_i || !wd_drv_i || kick;
    at_last  = (cnt_q == LAST);
    expire_o = !clear && at_last;
    if (clear || at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= wd_lvl_i;
      cnt_q  <= cnt_d;
    end
  end

  // Count parked at zero while the pin is undriven.
  assert_disabled_parks_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    !wd_drv_i |=> (cnt_q == '0)
  );

  // Count parked at zero while reset is asserted.
  assert_hold_parks_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == '0)
  );

  // A level change on a driven pin restarts the count.
  assert_edge_restarts_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    (wd_drv_i && (wd_lvl_i != prev_q)) |=> (cnt_q == '0)
  );

  // Timeout only while driven and outside reset.
  assert_expire_gated_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    expire_o |-> (wd_drv_i && !hold_i)
  );

endmodule

// File: rtl/supv_stretch.sv
module supv_stretch #(
  parameter int unsigned HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cause_i,
  output logic hold_o
);

  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic          hold_q, hold_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done;

  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    done   = (cnt_q == LAST);
    if (cause_i) begin
      hold_d = 1'b1;
      cnt_d  = '0;
    end else if (hold_q) begin
      if (done) begin
        hold_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
    end
  end

  assign hold_o = hold_q;

  // Any active cause leaves reset asserted after the edge.
  assert_cause_asserts_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    cause_i |=> hold_q
  );

  // Release only after a full quiet interval.
  assert_release_full_interval_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> ($past(cnt_q) == LAST && !$past(cause_i))
  );

  // A cause during the stretch reloads the count.
  assert_cause_reloads_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    cause_i |=> (cnt_q == '0)
  );

endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
  import supv_pkg::*;
#(
  parameter int unsigned RST_CYCLES  = 26_250_000,
  parameter int unsigned WDOG_CYCLES = 220_000_000,
  parameter int unsigned DEB_CYCLES  = 125_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic wdog_i,
  input  logic wdog_drv_i,
  input  logic man_rst_n_i,
  output logic cpu_rst_n_o,
  output logic cpu_rst_o
);

  // Supply starts "bad" and manual starts "released" out of chip reset.
  localparam logic [SYNC_WIDTH-1:0] SYNC_RST = SYNC_WIDTH'(1) << SYNC_MANUAL;

  logic [SYNC_WIDTH-1:0] raw_bus, sync_bus;
  logic                  supply_s, manual_s, wd_lvl_s, wd_drv_s;
  logic                  manual_lvl, wd_expire, hold;
  supv_cause_t           cause;
  logic                  any_cause;

  always_comb begin
    raw_bus              = '0;
    raw_bus[SYNC_SUPPLY] = supply_ok_i;
    raw_bus[SYNC_MANUAL] = man_rst_n_i;
    raw_bus[SYNC_WDLVL]  = wdog_i;
    raw_bus[SYNC_WDDRV]  = wdog_drv_i;
  end

  supv_sync #(
    .WIDTH   (SYNC_WIDTH),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_bus),
    .sync_o  (sync_bus)
  );

  assign supply_s = sync_bus[SYNC_SUPPLY];
  assign manual_s = sync_bus[SYNC_MANUAL];
  assign wd_lvl_s = sync_bus[SYNC_WDLVL];
  assign wd_drv_s = sync_bus[SYNC_WDDRV];

  supv_debounce #(
    .DEB_CYCLES (DEB_CYCLES),
    .RST_LEVEL  (1'b1)
  ) u_debounce (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   (manual_s),
    .level_o (manual_lvl)
  );

  supv_wdog #(
    .WDOG_CYCLES (WDOG_CYCLES)
  ) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .wd_lvl_i (wd_lvl_s),
    .wd_drv_i (wd_drv_s),
    .hold_i   (hold),
    .expire_o (wd_expire)
  );

  always_comb begin
    cause.supply_low = !supply_s;
    cause.manual     = !manual_lvl;
    cause.wdog       = wd_expire;
    any_cause        = |cause;
  end

  supv_stretch #(
    .HOLD_CYCLES (RST_CYCLES)
  ) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .cause_i (any_cause),
    .hold_o  (hold)
  );

  assign cpu_rst_o   = hold;
  assign cpu_rst_n_o = !hold;

  // Synchronized supply loss drives reset at the pins on the next edge.
  assert_supply_low_pins_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    !supply_s |=> (cpu_rst_o && !cpu_rst_n_o)
  );

  // Accepted manual request drives reset at the pins on the next edge.
  assert_manual_pins_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    !manual_lvl |=> cpu_rst_o
  );

endmodule

// File: tb/tb_supv_reset_ctrl.sv
module tb_supv_reset_ctrl;

  localparam int unsigned RST  = 8;
  localparam int unsigned WDOG = 20;
  localparam int unsigned DEB  = 4;
  localparam int unsigned LAT  = 2;

  logic clk, rst_n, supply_ok, wdog, wdog_drv, man_n;
  logic rst_lo, rst_hi;
  int   checks, errors;

  supv_reset_ctrl #(
    .RST_CYCLES  (RST),
    .WDOG_CYCLES (WDOG),
    .DEB_CYCLES  (DEB),
    .SYNC_STAGES (LAT)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok_i (supply_ok),
    .wdog_i      (wdog),
    .wdog_drv_i  (wdog_drv),
    .man_rst_n_i (man_n),
    .cpu_rst_n_o (rst_lo),
    .cpu_rst_o   (rst_hi)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int pol_bad;
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (rst_lo == rst_hi) pol_bad++;
  endtask

  // which: 0 = supply, 1 = manual. Low for len cycles, then high.
  task automatic pulse(input int which, input int len,
                       output int a_idx, output int r_idx, output int hi_cnt);
    int limit;
    limit = len + RST + DEB + 12;
    a_idx = -1; r_idx = -1; hi_cnt = 0;
    if (which == 0) supply_ok = 1'b0; else man_n = 1'b0;
    for (int i = 1; i <= limit; i++) begin
      step();
      if (rst_hi) hi_cnt++;
      if (rst_hi && a_idx < 0) a_idx = i;
      if (!rst_hi && a_idx >= 0 && r_idx < 0) r_idx = i;
      if (i == len) begin
        if (which == 0) supply_ok = 1'b1; else man_n = 1'b1;
      end
      if (r_idx >= 0) break;
    end
  endtask

  task automatic count_level(input logic lvl, input int limit, output int n);
    n = 0;
    while (rst_hi == lvl && n < limit) begin
      step();
      n++;
    end
  endtask

  task automatic settle();
    int n;
    count_level(1'b1, 4 * RST, n);
    repeat (DEB + 4) step();
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog timer expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a, r, h, n;
    checks = 0; errors = 0; pol_bad = 0;
    rst_n = 1'b0; supply_ok = 1'b1; wdog = 1'b0; wdog_drv = 1'b0; man_n = 1'b1;
    repeat (3) step();
    // R11 / R9: reset state
    check(rst_hi == 1'b1 && rst_lo == 1'b0, "R11 asserted in chip reset", rst_hi, 1);
    rst_n = 1'b1;
    count_level(1'b1, 4 * RST, n);
    check(n == RST + LAT, "R11 power-on release edge", n, RST + LAT);
    repeat (4) step();

    // R1 / R2: supply loss of several widths
    for (int len = 1; len <= 5; len++) begin
      pulse(0, len, a, r, h);
      check(a == LAT + 1, "R1 supply assert edge", a, LAT + 1);
      check(r == len + RST + LAT, "R2 supply release edge", r, len + RST + LAT);
      settle();
    end

    // R7 / R8: manual pulse sweep across the debounce boundary
    for (int w = 1; w <= DEB + 4; w++) begin
      pulse(1, w, a, r, h);
      if (w < DEB) begin
        check(h == 0, "R8 short manual pulse ignored", h, 0);
      end else begin
        check(a == DEB + LAT + 1, "R7 manual assert edge", a, DEB + LAT + 1);
        check(h == w + RST - 1, "R7 manual reset length", h, w + RST - 1);
      end
      settle();
    end

    // R10: supply glitch during the stretch reloads the interval
    supply_ok = 1'b0;
    repeat (2) step();
    supply_ok = 1'b1;
    repeat (LAT + 1 + RST / 2) step();
    check(rst_hi == 1'b1, "R10 still stretching", rst_hi, 1);
    supply_ok = 1'b0;
    step();
    supply_ok = 1'b1;
    count_level(1'b1, 4 * RST, n);
    check(n == RST + LAT, "R10 release after reload", n, RST + LAT);
    settle();

    // R6: undriven watchdog pin never resets
    wdog_drv = 1'b0;
    h = 0;
    for (int i = 0; i < 3 * WDOG; i++) begin
      step();
      if (rst_hi) h++;
    end
    check(h == 0, "R6 disabled watchdog quiet", h, 0);

    // R6: resume with counter at zero
    wdog_drv = 1'b1;
    count_level(1'b0, 4 * WDOG, n);
    check(n == WDOG + LAT, "R6 resume timeout edge", n, WDOG + LAT);
    // R4 / R5: periodic timeout pattern
    count_level(1'b1, 4 * RST, n);
    check(n == RST, "R4 watchdog reset length", n, RST);
    count_level(1'b0, 4 * WDOG, n);
    check(n == WDOG, "R5 restart from zero after release", n, WDOG);
    count_level(1'b1, 4 * RST, n);
    check(n == RST, "R5 second reset length", n, RST);

    // R3: kick period sweep around the watchdog interval
    for (int p = WDOG - 2; p <= WDOG + 2; p++) begin
      wdog_drv = 1'b0;
      settle();
      wdog_drv = 1'b1;
      wdog = ~wdog;
      h = 0;
      for (int i = 1; i <= 4 * WDOG + RST; i++) begin
        step();
        if (rst_hi) h++;
        if (i % p == 0) wdog = ~wdog;
      end
      if (p <= WDOG) check(h == 0, "R3 kicked watchdog quiet", h, 0);
      else           check(h > 0, "R3 slow kicks time out", h, 1);
    end
    wdog_drv = 1'b0;
    settle();

    check(pol_bad == 0, "R9 outputs complementary", pol_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule